// File: doc/BRIEF.md
# Low-Power Wake-up Source Controller

This controller decides how a mixed-signal companion die leaves its two low-power modes, Stop and Sleep. While the die is in either mode, the controller watches six digital sense lines, gated by enable bits, and five event inputs. These events are a forced-wake timer tick, a LIN wake request, a die-to-die link request, a reset request and a supply-loss flag. Each event counts only in the mode where it is valid. On a wake from Stop, the controller raises an interrupt toward the host and returns to Normal. On a wake from Sleep, it enters Reset for a fixed number of cycles and then returns to Normal.

The cause of each wake is latched into a source register. The host reads that register over a small register bus. The read clears the latched causes and the interrupt, and it lifts a lockout that otherwise refuses new Stop commands. A mode command must also trail that read by a minimum gap of clock cycles, or the command is dropped.

The enable bits and the sense-line levels are sampled at the moment of entry into a low-power mode. Only a departure from those captured levels counts as a wake.

Top module: `wk_ctrl`

## Requirements
- R1: After reset, the mode reads Normal (code 0), the interrupt is low, and the enable register (address 0) and the source register (address 1) read zero. Reads are combinational, and an address of 3 reads zero.
- R2: In a low-power mode, a change on a sense line whose enable bit was set at entry causes a wake. A change on a line whose enable bit was clear has no effect, and the mode is unchanged.
- R3: A wake in Stop (code 1) returns the mode to Normal on the wake edge and raises the interrupt. The interrupt stays high until the source register is read.
- R4: A wake in Sleep (code 2) moves the mode to Reset (code 3) for RST_HOLD cycles and then to Normal, without raising the interrupt.
- R5: The die-to-die request (source bit 3) and the reset request (source bit 4) wake only from Stop, and are ignored in Sleep.
- R6: Supply loss (source bit 5) wakes only from Sleep, and is ignored in Stop.
- R7: If a forced wake (source bit 1) and a sense change (source bit 0) are present on the same wake edge, only bit 1 is recorded.
- R8: After any wake, a Stop command (value 1 written to address 2) is rejected until the source register has been read.
- R9: A mode command written fewer than GAP cycles after a source-register read is rejected. Written exactly GAP cycles after the read, it is accepted. Mode commands are accepted only in Normal; value 2 requests Sleep.
- R10: A read strobe at address 1 clears the source register, the interrupt and the Stop lockout on the next edge.
- R11: The enable bits and the sense-line baseline are captured on the edge that enters a low-power mode. Rewriting the enable register later does not change which lines can wake, and a line already high at entry does not wake.
- R12: A sense line passes through two synchronizer flops. A level applied before edge k produces the wake on edge k+2.
- R13: The forced, LIN (source bit 2), die-to-die, reset-request and supply-loss inputs act on the edge at which they are first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr_i | input | 2 | Register address: 0 enables, 1 sources, 2 mode |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data |
| sense_i | input | SENSE_N | Asynchronous digital sense lines |
| frc_wake_i | input | 1 | Forced-wake timer event |
| lin_wake_i | input | 1 | LIN wake request |
| d2d_wake_i | input | 1 | Die-to-die link wake request |
| rst_wake_i | input | 1 | Internal or external reset request |
| vsup_lost_i | input | 1 | Supply-loss flag |
| mode_o | output | 2 | Current mode: 0 Normal, 1 Stop, 2 Sleep, 3 Reset |
| irq_o | output | 1 | Interrupt toward the host after a Stop wake |

## Verification
The event inputs, register writes and mode commands all change state on the first edge that samples them. A sense-line change appears two edges later, because of the synchronizer. Reset lasts RST_HOLD cycles from the Sleep wake edge, and read data is due in the same cycle as the address. The bench drives inputs just after each rising edge. It keeps a behavioural per-cycle model that applies these latencies, and it compares mode, interrupt and read data with that model at every falling edge, so each result is checked in exactly the cycle it falls due.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_STOP   = 2'd1,
    MD_SLEEP  = 2'd2,
    MD_RESET  = 2'd3
  } wk_mode_e;

  localparam int SRC_W      = 6;
  localparam int SRC_SENSE  = 0;
  localparam int SRC_FORCED = 1;
  localparam int SRC_LIN    = 2;
  localparam int SRC_D2D    = 3;
  localparam int SRC_RSTRQ  = 4;
  localparam int SRC_SUPPLY = 5;

  localparam logic [1:0] ADDR_ENA  = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
endpackage

// File: rtl/wk_sense_detect.sv
module wk_sense_detect #(
  parameter int SENSE_N = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SENSE_N-1:0] sense_i,
  input  logic [SENSE_N-1:0] en_i,
  input  logic               capture_i,
  output logic               change_o
);
  logic [SENSE_N-1:0] sync1_q, sync2_q, base_q, enl_q;

  // two-flop synchronizer per line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= sense_i;
      sync2_q <= sync1_q;
    end
  end

  // baseline levels and enable mask frozen at low-power entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      enl_q  <= '0;
    end else if (capture_i) begin
      base_q <= sync2_q;
      enl_q  <= en_i;
    end
  end

  assign change_o = |((sync2_q ^ base_q) & enl_q);

  assert_mask_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> ($stable(enl_q) && $stable(base_q)));
endmodule

// File: rtl/wk_src_select.sv
module wk_src_select
  import wk_pkg::*;
(
  input  wk_mode_e         mode_i,
  input  logic             change_i,
  input  logic             frc_i,
  input  logic             lin_i,
  input  logic             d2d_i,
  input  logic             rstrq_i,
  input  logic             vsup_i,
  output logic [SRC_W-1:0] src_o,
  output logic             wake_o
);
  logic in_stop, in_sleep, low_pwr;

  always_comb begin
    in_stop  = (mode_i == MD_STOP);
    in_sleep = (mode_i == MD_SLEEP);
    low_pwr  = in_stop | in_sleep;
    src_o             = '0;
    src_o[SRC_FORCED] = low_pwr & frc_i;
    src_o[SRC_SENSE]  = low_pwr & change_i & ~frc_i;
    src_o[SRC_LIN]    = low_pwr & lin_i;
    src_o[SRC_D2D]    = in_stop & d2d_i;
    src_o[SRC_RSTRQ]  = in_stop & rstrq_i;
    src_o[SRC_SUPPLY] = in_sleep & vsup_i;
    wake_o            = |src_o;
  end
endmodule

// File: rtl/wk_mode_ctrl.sv
module wk_mode_ctrl
  import wk_pkg::*;
#(
  parameter int GAP      = 2,
  parameter int RST_HOLD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             cmd_we_i,
  input  logic [1:0]       cmd_i,
  input  logic             src_rd_i,
  output wk_mode_e         mode_o,
  output logic             irq_o,
  output logic [SRC_W-1:0] src_o,
  output logic             capture_o
);
  localparam int GAP_W = $clog2(GAP + 1);
  localparam int RST_W = $clog2(RST_HOLD + 1);

  wk_mode_e         mode_q, mode_d;
  logic             irq_q, irq_d, lock_q, lock_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [RST_W-1:0] rcnt_q, rcnt_d;
  logic             cmd_ok, go_stop, go_sleep;

  always_comb begin
    cmd_ok   = cmd_we_i && (mode_q == MD_NORMAL) && (gap_q == '0);
    go_stop  = cmd_ok && (cmd_i == 2'(MD_STOP)) && !lock_q;
    go_sleep = cmd_ok && (cmd_i == 2'(MD_SLEEP));
    capture_o = go_stop | go_sleep;
  end

  always_comb begin
    mode_d = mode_q;
    irq_d  = irq_q;
    lock_d = lock_q;
    src_d  = src_q;
    gap_d  = gap_q;
    rcnt_d = rcnt_q;
    if (src_rd_i) begin
      src_d  = '0;
      irq_d  = 1'b0;
      lock_d = 1'b0;
      gap_d  = GAP_W'(GAP - 1);
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end
    unique case (mode_q)
      MD_NORMAL: begin
        if (go_stop)       mode_d = MD_STOP;
        else if (go_sleep) mode_d = MD_SLEEP;
      end
      MD_STOP: if (wake_i) begin
        mode_d = MD_NORMAL;
        irq_d  = 1'b1;
        lock_d = 1'b1;
        src_d  = src_d | src_i;
      end
      MD_SLEEP: if (wake_i) begin
        mode_d = MD_RESET;
        rcnt_d = RST_W'(RST_HOLD - 1);
        lock_d = 1'b1;
        src_d  = src_d | src_i;
      end
      MD_RESET: begin
        if (rcnt_q == '0) mode_d = MD_NORMAL;
        else              rcnt_d = rcnt_q - 1'b1;
      end
      default: mode_d = MD_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_NORMAL;
      irq_q  <= 1'b0;
      lock_q <= 1'b0;
      src_q  <= '0;
      gap_q  <= '0;
      rcnt_q <= '0;
    end else begin
      mode_q <= mode_d;
      irq_q  <= irq_d;
      lock_q <= lock_d;
      src_q  <= src_d;
      gap_q  <= gap_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign mode_o = mode_q;
  assign irq_o  = irq_q;
  assign src_o  = src_q;

  assert_irq_from_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(mode_q) == MD_STOP && mode_q == MD_NORMAL));
  assert_sleep_exit_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MD_SLEEP && mode_q != MD_SLEEP) |-> mode_q == MD_RESET);
  assert_d2d_stop_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q[SRC_D2D]) |-> $past(mode_q) == MD_STOP);
  assert_supply_sleep_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q[SRC_SUPPLY]) |-> $past(mode_q) == MD_SLEEP);
  assert_forced_over_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_q[SRC_FORCED] && src_q[SRC_SENSE]));
  assert_stop_needs_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_STOP && $past(mode_q) == MD_NORMAL) |-> !$past(lock_q));
  assert_entry_after_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_STOP || mode_q == MD_SLEEP) && $past(mode_q) == MD_NORMAL)
      |-> $past(gap_q) == '0);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_i && !wake_i) |=> (src_q == '0 && !irq_q && !lock_q));
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int SENSE_N  = 6,
  parameter int DATA_W   = 8,
  parameter int GAP      = 2,
  parameter int RST_HOLD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [SENSE_N-1:0] sense_i,
  input  logic               frc_wake_i,
  input  logic               lin_wake_i,
  input  logic               d2d_wake_i,
  input  logic               rst_wake_i,
  input  logic               vsup_lost_i,
  output logic [1:0]         mode_o,
  output logic               irq_o
);
  logic [SENSE_N-1:0] en_q;
  logic               en_we, cmd_we, src_rd, capture, change, wake;
  logic [SRC_W-1:0]   src_evt, src_reg;
  wk_mode_e           mode;

  assign en_we  = bus_wr_i && (bus_addr_i == ADDR_ENA);
  assign cmd_we = bus_wr_i && (bus_addr_i == ADDR_MODE);
  assign src_rd = bus_rd_i && (bus_addr_i == ADDR_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= bus_wdata_i[SENSE_N-1:0];
  end

  wk_sense_detect #(.SENSE_N(SENSE_N)) u_sense (
    .clk(clk), .rst_n(rst_n), .sense_i(sense_i), .en_i(en_q),
    .capture_i(capture), .change_o(change)
  );

  wk_src_select u_sel (
    .mode_i(mode), .change_i(change), .frc_i(frc_wake_i), .lin_i(lin_wake_i),
    .d2d_i(d2d_wake_i), .rstrq_i(rst_wake_i), .vsup_i(vsup_lost_i),
    .src_o(src_evt), .wake_o(wake)
  );

  wk_mode_ctrl #(.GAP(GAP), .RST_HOLD(RST_HOLD)) u_mode (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .src_i(src_evt),
    .cmd_we_i(cmd_we), .cmd_i(bus_wdata_i[1:0]), .src_rd_i(src_rd),
    .mode_o(mode), .irq_o(irq_o), .src_o(src_reg), .capture_o(capture)
  );

  assign mode_o = mode;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_ENA:  bus_rdata_o[SENSE_N-1:0] = en_q;
      ADDR_SRC:  bus_rdata_o[SRC_W-1:0]   = src_reg;
      ADDR_MODE: bus_rdata_o[1:0]         = mode;
      default:   bus_rdata_o = '0;
    endcase
  end

  assert_enable_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_q == $past(bus_wdata_i[SENSE_N-1:0]));
endmodule

// File: tb/tb_wk_ctrl.sv
module tb_wk_ctrl;
  localparam int RST_HOLD = 4;
  localparam int GAP      = 2;

  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [5:0] sense = 0;
  logic       frc = 0, lin = 0, d2d = 0, rstw = 0, vsup = 0;
  logic [1:0] mode;
  logic       irq;

  wk_ctrl #(.GAP(GAP), .RST_HOLD(RST_HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sense_i(sense), .frc_wake_i(frc), .lin_wake_i(lin), .d2d_wake_i(d2d),
    .rst_wake_i(rstw), .vsup_lost_i(vsup), .mode_o(mode), .irq_o(irq)
  );

  always #5 clk = ~clk;

  int    nchk = 0, nfail = 0, cyc = 0;
  string cur = "R1";

  // behavioural reference state
  int         m_mode, m_irq, m_lock, m_gap, m_rcnt;
  logic [5:0] m_src, m_en, m_s1, m_s2, m_base, m_enl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_irq = 0; m_lock = 0; m_gap = 0; m_rcnt = 0;
      m_src = 0; m_en = 0; m_s1 = 0; m_s2 = 0; m_base = 0; m_enl = 0;
    end else begin
      int         lp, nmode, nirq, nlock, ngap, nrcnt;
      logic [5:0] ev, nsrc, nen, nbase, nenl;
      logic       chg;
      lp  = (m_mode == 1 || m_mode == 2);
      chg = lp && (((m_s2 ^ m_base) & m_enl) != 0);
      ev  = 0;
      if (lp && frc)            ev[1] = 1;
      else if (chg)             ev[0] = 1;
      if (lp && lin)            ev[2] = 1;
      if (m_mode == 1 && d2d)   ev[3] = 1;
      if (m_mode == 1 && rstw)  ev[4] = 1;
      if (m_mode == 2 && vsup)  ev[5] = 1;
      nmode = m_mode; nirq = m_irq; nlock = m_lock; nsrc = m_src;
      nrcnt = m_rcnt; nen = m_en; nbase = m_base; nenl = m_enl;
      ngap  = (m_gap > 0) ? m_gap - 1 : 0;
      if (bus_rd && bus_addr == 1) begin
        nsrc = 0; nirq = 0; nlock = 0; ngap = GAP - 1;
      end
      if (bus_wr && bus_addr == 0) nen = bus_wdata[5:0];
      if (m_mode == 0) begin
        if (bus_wr && bus_addr == 2 && m_gap == 0 &&
            ((bus_wdata[1:0] == 1 && !m_lock) || bus_wdata[1:0] == 2)) begin
          nmode = bus_wdata[1:0]; nbase = m_s2; nenl = m_en;
        end
      end else if (m_mode == 3) begin
        if (m_rcnt == 0) nmode = 0; else nrcnt = m_rcnt - 1;
      end else if (ev != 0) begin
        nlock = 1; nsrc = nsrc | ev;
        if (m_mode == 1) begin nmode = 0; nirq = 1; end
        else begin nmode = 3; nrcnt = RST_HOLD - 1; end
      end
      m_mode = nmode; m_irq = nirq; m_lock = nlock; m_gap = ngap;
      m_rcnt = nrcnt; m_src = nsrc; m_en = nen; m_base = nbase; m_enl = nenl;
      m_s2 = m_s1; m_s1 = sense;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", cur, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] erd;
    case (bus_addr)
      2'd0: erd = {2'b0, m_en};
      2'd1: erd = {2'b0, m_src};
      2'd2: erd = 8'(m_mode);
      default: erd = 0;
    endcase
    chk("mode", {6'b0, mode}, 8'(m_mode));
    chk("irq", {7'b0, irq}, 8'(m_irq));
    chk("rdata", bus_rdata, erd);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL watchdog expired, all requirements, actual=%0d expected<=20000", cyc);
      summary();
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic idle(int n); bus_addr = 1; repeat (n) tick(); endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
  endtask
  task automatic rd(logic [1:0] a);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0;
  endtask

  initial begin
    cur = "R1";
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    idle(2); bus_addr = 0; tick(); bus_addr = 3; tick(); bus_addr = 2; tick();
    // enable lines 0 and 2, enter Stop
    wr(0, 8'b0000_0101); idle(2);
    wr(2, 8'd1); idle(3);
    cur = "R2";  sense[1] = 1; idle(6);          // disabled line: stays in Stop
    cur = "R12"; sense[2] = 1; tick(); tick(); tick(); idle(2); // wake on third edge
    cur = "R3";  idle(4);                         // interrupt held
    cur = "R8";  wr(2, 8'd1); idle(3);            // locked: rejected
    cur = "R10"; rd(1); idle(1);
    cur = "R9";  rd(1); wr(2, 8'd2); wr(2, 8'd2); idle(2); // early rejected, next accepted
    cur = "R11"; wr(0, 8'd0); idle(3);            // enables frozen, line 2 high at entry
    sense[2] = 0; idle(4);                        // frozen mask still wakes
    cur = "R4";  idle(8);
    cur = "R10"; rd(1); idle(3);
    cur = "R5";  wr(2, 8'd2); d2d = 1; rstw = 1; idle(3); d2d = 0; rstw = 0;
    cur = "R6";  vsup = 1; tick(); vsup = 0; idle(8);
    rd(1); idle(3);
    wr(2, 8'd1); vsup = 1; idle(3); vsup = 0;     // ignored in Stop
    cur = "R5";  d2d = 1; tick(); d2d = 0; idle(2);
    rd(1); idle(3);
    cur = "R13"; wr(2, 8'd1); rstw = 1; tick(); rstw = 0; idle(2);
    rd(1); idle(3);
    cur = "R7";  wr(0, 8'h3f); idle(2); wr(2, 8'd1); idle(3);
    sense[0] = 1; tick(); tick(); frc = 1; tick(); frc = 0; idle(3);
    rd(1); idle(3);
    cur = "R13"; wr(2, 8'd1); idle(2); lin = 1; tick(); lin = 0; idle(3);
    rd(1); idle(3);
    cur = "R9";  rd(1); wr(2, 8'd1); wr(2, 8'd1); idle(2); frc = 1; tick(); frc = 0; idle(2);
    summary();
  end
endmodule